// File: doc/BRIEF.md
# Descriptor-Driven Command Walker

This block is the per-port sequencer that runs one storage command from descriptors held in memory. Software sets the run bit in the engine control word and then posts a slot number. The engine reads a 32-bit pointer from a lookup table at `table_base + 4*slot`. It then fetches the leading words of a 32-byte command block at that pointer and follows a chain of 8-byte region descriptors. For each region it emits one transfer request carrying address, length and direction. A running byte count is kept across the chain.

Validation follows the descriptors themselves. A block that is not marked valid is refused before the chain is touched. A region longer than the largest length the data path may accept is refused and never issued. At the end of the chain the sum of the region lengths is compared with the total the block declares. The outcome is written back into the response byte of the command block and reflected in the status bits. An optional one-cycle interrupt pulse marks completion. Moving the data and driving the device are left to neighbouring blocks.

Memory access uses a single request/ready port carrying 32-bit words. A request and its address stay stable until `mem_ready` is seen high. Read data is taken in the cycle that `mem_ready` is high.

Top module: `cmdwalk_top`

## Requirements
- R1: While the run bit (control bit 7) is clear, a slot posting is ignored: no memory request is made and the status stays zero.
- R2: With the run bit set, a posting of slot s makes the first memory read at `table_base + 4*s`. The word returned is the command block address. The next reads fetch block word 0 (byte 0 response flags, byte 3 control flags), word 1 (total length) and word 2 (first descriptor address) at that address, +4 and +8.
- R3: If control flag bit 0 (valid) is clear, the engine issues no transfer. It writes response byte 0x84 (ignored, bit 2, plus block error, bit 7) and sets status 0x02 (bit 1, block error).
- R4: Each descriptor is read as word 0 = address and word 1 = {flags[31:24], reserved[23:16], length[15:0]}. It produces one transfer request with that address and length, and with `xfer_write` equal to flag bit 5.
- R5: The chain advances by 8 bytes per descriptor and ends after the first descriptor whose flag bit 7 is set.
- R6: A descriptor length above 65024 bytes is never issued. The walk stops with response byte 0x80 and status 0x02.
- R7: At the end of the chain, a length sum above the declared total gives response 0xC0 (overflow bit 6 plus bit 7). A sum below it gives 0xA0 (underflow bit 5 plus bit 7). Either case gives status 0x02.
- R8: A sum equal to the total gives response 0x01 (done, bit 0) and status 0x80 (bit 7, done).
- R9: The write-back leaves bytes 1 to 3 of block word 0 unchanged. It is followed by exactly one `irq_pulse` cycle only if control flag bit 3 is set.
- R10: `byte_total` holds the sum of the lengths of the transfers issued for the current command. It is cleared when a posting is accepted.
- R11: Writing control bit 5 (engine reset) returns the engine to idle, drops any request, clears the status and clears the run bit. The interrupted block is not written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Engine control word write strobe |
| ctl_wdata | input | 16 | Control word: bit 7 run, bit 5 engine reset |
| post_valid | input | 1 | Slot posting strobe |
| post_slot | input | 5 | Posted slot index |
| table_base | input | 32 | Byte address of the lookup table |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory word byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts request / read data valid |
| mem_rdata | input | 32 | Read data |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_addr | output | 32 | Region address |
| xfer_len | output | 16 | Region length in bytes |
| xfer_write | output | 1 | Region direction (1 = write) |
| xfer_ready | input | 1 | Transfer request accepted |
| byte_total | output | 32 | Running byte count of issued regions |
| status | output | 8 | Bit 7 done, bit 1 block error |
| irq_pulse | output | 1 | One-cycle completion interrupt |

## Verification
The assertions check on every cycle the rules that do not depend on memory contents. A request holds its address until accepted. Memory and transfer requests never overlap. No issued region exceeds the length limit. Done and error are never both set. An interrupt lasts one cycle. An engine reset empties the outputs in the following cycle. Only the bench scenarios can show which addresses are walked, which response byte lands in memory, and how overflow, underflow, invalid and oversized blocks are told apart. They also show that bytes 1 to 3 survive the write-back and that a posting without the run bit has no effect.

// File: rtl/cmdwalk_pkg.sv
package cmdwalk_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_LUT, S_W0, S_W1, S_W2, S_D0, S_D1, S_XFER, S_WB
  } walk_state_e;

  localparam int CTL_ENG_RST = 5;
  localparam int CTL_RUN     = 7;

  localparam int CB_VALID = 0;
  localparam int CB_IEN   = 3;

  localparam logic [7:0] RESP_DONE    = 8'h01;
  localparam logic [7:0] RESP_IGNORED = 8'h04;
  localparam logic [7:0] RESP_UNDER   = 8'h20;
  localparam logic [7:0] RESP_OVER    = 8'h40;
  localparam logic [7:0] RESP_BLKERR  = 8'h80;

  localparam logic [7:0] STAT_BLKERR = 8'h02;
  localparam logic [7:0] STAT_DONE   = 8'h80;
endpackage

// File: rtl/cmdwalk_rst_sync.sv
module cmdwalk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/cmdwalk_region_chk.sv
module cmdwalk_region_chk #(
  parameter int LEN_W   = 16,
  parameter int MAX_LEN = 65024
) (
  input  logic [31:0]      desc_w1,
  output logic [LEN_W-1:0] len,
  output logic             is_last,
  output logic             is_write,
  output logic             too_long
);
  logic [7:0] flags;
  assign flags    = desc_w1[31:24];
  assign len      = desc_w1[LEN_W-1:0];
  assign is_last  = flags[7];
  assign is_write = flags[5];
  assign too_long = ({1'b0, len} > (LEN_W+1)'(MAX_LEN));
endmodule

// File: rtl/cmdwalk_tally.sv
module cmdwalk_tally #(
  parameter int SUM_W = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add,
  input  logic [LEN_W-1:0] len,
  input  logic [SUM_W-1:0] declared,
  output logic [SUM_W-1:0] sum,
  output logic             sum_over,
  output logic             sum_under
);
  logic [SUM_W-1:0] sum_q, sum_d, sum_next;

  assign sum_next  = sum_q + SUM_W'(len);
  assign sum_over  = sum_next > declared;
  assign sum_under = sum_next < declared;

  always_comb begin
    sum_d = sum_q;
    if (clr)      sum_d = '0;
    else if (add) sum_d = sum_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign sum = sum_q;
endmodule

// File: rtl/cmdwalk_top.sv
module cmdwalk_top
  import cmdwalk_pkg::*;
#(
  parameter int AW      = 32,
  parameter int SLOT_W  = 5,
  parameter int LEN_W   = 16,
  parameter int MAX_LEN = 65024,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [15:0]       ctl_wdata,
  input  logic              post_valid,
  input  logic [SLOT_W-1:0] post_slot,
  input  logic [AW-1:0]     table_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic              xfer_valid,
  output logic [AW-1:0]     xfer_addr,
  output logic [LEN_W-1:0]  xfer_len,
  output logic              xfer_write,
  input  logic              xfer_ready,
  output logic [31:0]       byte_total,
  output logic [7:0]        status,
  output logic              irq_pulse
);
  localparam int DESC_BYTES = 8;

  logic rst_s_n;
  cmdwalk_rst_sync #(.STAGES(SYNC_N)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s_n));

  walk_state_e      state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [AW-1:0]    ptr_q, ptr_d, dptr_q, dptr_d, dadr_q, dadr_d;
  logic [31:0]      dw1_q, dw1_d, total_q, total_d;
  logic [31:8]      w0_q, w0_d;
  logic [7:0]       resp_q, resp_d, stat_q, stat_d;
  logic             run_q, run_d, irq_q, irq_d;
  logic             eng_rst, start, fin, t_clr, t_add;

  logic [LEN_W-1:0] r_len;
  logic             r_last, r_wr, r_long, s_over, s_under;

  cmdwalk_region_chk #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_chk_rgn (
    .desc_w1(dw1_q), .len(r_len), .is_last(r_last), .is_write(r_wr), .too_long(r_long));

  cmdwalk_tally #(.SUM_W(32), .LEN_W(LEN_W)) u_tally (
    .clk(clk), .rst_n(rst_s_n), .clr(t_clr), .add(t_add), .len(r_len),
    .declared(total_q), .sum(byte_total), .sum_over(s_over), .sum_under(s_under));

  assign eng_rst = ctl_wr & ctl_wdata[CTL_ENG_RST];
  assign start   = run_q & post_valid & (state_q == S_IDLE);

  always_comb begin
    state_d = state_q; slot_d = slot_q; ptr_d = ptr_q; dptr_d = dptr_q;
    dadr_d = dadr_q; dw1_d = dw1_q; total_d = total_q; w0_d = w0_q;
    resp_d = resp_q; fin = 1'b0; t_clr = 1'b0; t_add = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        slot_d = post_slot; t_clr = 1'b1; state_d = S_LUT;
      end
      S_LUT: if (mem_ready) begin ptr_d = mem_rdata[AW-1:0]; state_d = S_W0; end
      S_W0: if (mem_ready) begin
        w0_d = mem_rdata[31:8];
        if (!mem_rdata[24+CB_VALID]) begin
          resp_d = RESP_IGNORED | RESP_BLKERR; state_d = S_WB;
        end else state_d = S_W1;
      end
      S_W1: if (mem_ready) begin total_d = mem_rdata; state_d = S_W2; end
      S_W2: if (mem_ready) begin dptr_d = mem_rdata[AW-1:0]; state_d = S_D0; end
      S_D0: if (mem_ready) begin dadr_d = mem_rdata[AW-1:0]; state_d = S_D1; end
      S_D1: if (mem_ready) begin dw1_d = mem_rdata; state_d = S_XFER; end
      S_XFER: begin
        if (r_long) begin
          resp_d = RESP_BLKERR; state_d = S_WB;
        end else if (xfer_ready) begin
          t_add = 1'b1;
          if (r_last) begin
            if (s_over)       resp_d = RESP_OVER | RESP_BLKERR;
            else if (s_under) resp_d = RESP_UNDER | RESP_BLKERR;
            else              resp_d = RESP_DONE;
            state_d = S_WB;
          end else begin
            dptr_d = dptr_q + AW'(DESC_BYTES); state_d = S_D0;
          end
        end
      end
      S_WB: if (mem_ready) begin fin = 1'b1; state_d = S_IDLE; end
      default: state_d = S_IDLE;
    endcase
    if (eng_rst) begin state_d = S_IDLE; fin = 1'b0; end
  end

  always_comb begin
    run_d = run_q;
    if (ctl_wr) run_d = ctl_wdata[CTL_RUN] & ~ctl_wdata[CTL_ENG_RST];
    stat_d = stat_q;
    if (eng_rst || start) stat_d = '0;
    else if (fin)         stat_d = resp_q[7] ? STAT_BLKERR : STAT_DONE;
    irq_d = fin & w0_q[24+CB_IEN];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= S_IDLE; slot_q <= '0; ptr_q <= '0; dptr_q <= '0; dadr_q <= '0;
      dw1_q <= '0; total_q <= '0; w0_q <= '0; resp_q <= '0; stat_q <= '0;
      run_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      state_q <= state_d; slot_q <= slot_d; ptr_q <= ptr_d; dptr_q <= dptr_d;
      dadr_q <= dadr_d; dw1_q <= dw1_d; total_q <= total_d; w0_q <= w0_d;
      resp_q <= resp_d; stat_q <= stat_d; run_q <= run_d; irq_q <= irq_d;
    end
  end

  always_comb begin
    mem_req = 1'b1; mem_we = 1'b0; mem_wdata = {w0_q, resp_q};
    unique case (state_q)
      S_LUT:   mem_addr = table_base + AW'({slot_q, 2'b00});
      S_W0:    mem_addr = ptr_q;
      S_W1:    mem_addr = ptr_q + AW'(4);
      S_W2:    mem_addr = ptr_q + AW'(8);
      S_D0:    mem_addr = dptr_q;
      S_D1:    mem_addr = dptr_q + AW'(4);
      S_WB:    begin mem_addr = ptr_q; mem_we = 1'b1; end
      default: begin mem_addr = '0; mem_req = 1'b0; end
    endcase
  end

  assign xfer_valid = (state_q == S_XFER) & ~r_long;
  assign xfer_addr  = dadr_q;
  assign xfer_len   = r_len;
  assign xfer_write = r_wr;
  assign status     = stat_q;
  assign irq_pulse  = irq_q;

  logic unused_bits;
  assign unused_bits = ^{ctl_wdata[15:8], ctl_wdata[6], ctl_wdata[4:0]};
endmodule

// File: rtl/cmdwalk_checker.sv
module cmdwalk_checker #(
  parameter int AW      = 32,
  parameter int LEN_W   = 16,
  parameter int MAX_LEN = 65024
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic [15:0]      ctl_wdata,
  input logic             mem_req,
  input logic             mem_ready,
  input logic [AW-1:0]    mem_addr,
  input logic             xfer_valid,
  input logic [LEN_W-1:0] xfer_len,
  input logic [7:0]       status,
  input logic             irq_pulse
);
  // R2: a pending memory request keeps its address until accepted
  p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !(ctl_wr && ctl_wdata[5])) |=> (mem_req && $stable(mem_addr)));

  // R4: descriptor fetch and region issue never happen together
  p_single_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && xfer_valid));

  // R6: no issued region exceeds the length limit
  p_len_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> ({1'b0, xfer_len} <= (LEN_W+1)'(MAX_LEN)));

  // R8: done and block error are exclusive
  p_stat_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[7] && status[1]));

  // R9: the interrupt is a single-cycle pulse
  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  // R11: engine reset empties every output in the next cycle
  p_eng_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[5]) |=> (status == 8'h00 && !mem_req && !xfer_valid && !irq_pulse));
endmodule

bind cmdwalk_top cmdwalk_checker #(.AW(AW), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_checker (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .mem_req(mem_req), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .xfer_valid(xfer_valid), .xfer_len(xfer_len), .status(status), .irq_pulse(irq_pulse));

// File: tb/cmdwalk_top_test.sv
`timescale 1ns/1ps
module cmdwalk_top_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ctl_wr, post_valid, mem_req, mem_we, mem_ready, xfer_valid, xfer_write, xfer_ready, irq_pulse;
  logic [15:0] ctl_wdata, xfer_len;
  logic [4:0]  post_slot;
  logic [31:0] table_base, mem_addr, mem_wdata, mem_rdata, xfer_addr, byte_total;
  logic [7:0]  status;

  cmdwalk_top uut (.*);

  logic [31:0] mem [0:1023];
  logic ph;
  assign mem_ready  = ph;
  assign xfer_ready = ph;
  assign mem_rdata  = mem[mem_addr[11:2]];

  int rd_cnt, xf_cnt, irq_cnt, checks, fails;
  logic [31:0] first_rd;
  logic [31:0] xf_a [0:3];
  logic [15:0] xf_l [0:3];
  logic        xf_w [0:3];

  always @(posedge clk) begin
    if (!rst_n) ph <= 1'b0; else ph <= ~ph;
    if (mem_req && mem_ready) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else begin
        if (rd_cnt == 0) first_rd <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
    if (xfer_valid && xfer_ready && xf_cnt < 4) begin
      xf_a[xf_cnt] <= xfer_addr; xf_l[xf_cnt] <= xfer_len; xf_w[xf_cnt] <= xfer_write;
      xf_cnt <= xf_cnt + 1;
    end
    if (irq_pulse) irq_cnt <= irq_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [15:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  task automatic post(input logic [4:0] s);
    @(negedge clk); rd_cnt = 0; xf_cnt = 0; irq_cnt = 0;
    post_valid = 1'b1; post_slot = s;
    @(negedge clk); post_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 300 && status == 8'h00; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // block at 0x200, chain at 0x400: two regions 0x100 (write) + 0x200 (read, end)
  task automatic setup(input logic [7:0] cflags, input logic [31:0] total);
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    mem[(32'h100 + 4*3) >> 2] = 32'h200;
    mem[32'h200 >> 2] = {cflags, 8'h50, 8'h00, 8'h00};
    mem[32'h204 >> 2] = total;
    mem[32'h208 >> 2] = 32'h400;
    mem[32'h400 >> 2] = 32'h1000; mem[32'h404 >> 2] = 32'h2000_0100;
    mem[32'h408 >> 2] = 32'h2000; mem[32'h40C >> 2] = 32'h8000_0200;
  endtask

  task automatic t_reset();
    chk("R11 reset status", status, 0);
    chk("R11 reset mem_req", mem_req, 0);
    chk("R9 reset irq", irq_pulse, 0);
  endtask

  task automatic t_no_run();
    setup(8'h0D, 32'h300);
    post(5'd3);
    repeat (30) @(negedge clk);
    chk("R1 reads without run", rd_cnt, 0);
    chk("R1 status without run", status, 0);
  endtask

  task automatic t_good();
    setup(8'h0D, 32'h300);
    ctl(16'h0080); post(5'd3); wait_done();
    chk("R2 first read addr", first_rd, 32'h10C);
    chk("R4 xfer count", xf_cnt, 2);
    chk("R4 xfer0 addr", xf_a[0], 32'h1000);
    chk("R4 xfer0 len", xf_l[0], 16'h100);
    chk("R4 xfer0 write", xf_w[0], 1);
    chk("R5 xfer1 addr", xf_a[1], 32'h2000);
    chk("R5 xfer1 write", xf_w[1], 0);
    chk("R10 byte total", byte_total, 32'h300);
    chk("R8 response", mem[32'h200 >> 2], 32'h0D50_0001);
    chk("R8 status", status, 8'h80);
    chk("R9 irq with ien", irq_cnt, 1);
  endtask

  task automatic t_invalid();
    setup(8'h08, 32'h300);
    post(5'd3); wait_done();
    chk("R3 response", mem[32'h200 >> 2], 32'h0850_0084);
    chk("R3 status", status, 8'h02);
    chk("R3 no xfer", xf_cnt, 0);
    chk("R9 irq on error", irq_cnt, 1);
  endtask

  task automatic t_over();
    setup(8'h05, 32'h200);
    post(5'd3); wait_done();
    chk("R7 overflow resp", mem[32'h200 >> 2], 32'h0550_00C0);
    chk("R7 overflow status", status, 8'h02);
    chk("R9 no irq without ien", irq_cnt, 0);
  endtask

  task automatic t_under();
    setup(8'h05, 32'h400);
    post(5'd3); wait_done();
    chk("R7 underflow resp", mem[32'h200 >> 2], 32'h0550_00A0);
    chk("R10 clear on post", byte_total, 32'h300);
  endtask

  task automatic t_long();
    setup(8'h05, 32'hFE01);
    mem[32'h404 >> 2] = 32'h8000_FE01;
    post(5'd3); wait_done();
    chk("R6 oversize resp", mem[32'h200 >> 2], 32'h0550_0080);
    chk("R6 oversize status", status, 8'h02);
    chk("R6 no xfer", xf_cnt, 0);
  endtask

  task automatic t_eng_reset();
    setup(8'h0D, 32'h300);
    post(5'd3);
    repeat (6) @(negedge clk);
    ctl(16'h0020);
    chk("R11 status after reset", status, 0);
    chk("R11 req after reset", mem_req, 0);
    repeat (30) @(negedge clk);
    chk("R11 no write-back", mem[32'h200 >> 2], 32'h0D50_0000);
    post(5'd3); repeat (30) @(negedge clk);
    chk("R11 run cleared", rd_cnt, 0);
  endtask

  initial begin
    checks = 0; fails = 0; rd_cnt = 0; xf_cnt = 0; irq_cnt = 0;
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; post_valid = 1'b0; post_slot = '0;
    table_base = 32'h100;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_no_run();
    t_good();
    t_invalid();
    t_over();
    t_under();
    t_long();
    t_eng_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule